// File: doc/BRIEF.md
# Paired-address match-and-patch redirector

This block sits on the microcode fetch path, between the sequencer's next-address logic and the code store. It keeps a table of 32 programmable redirection entries. In every cycle it compares the incoming 16-bit micro-address against every entry whose present flag is set. When an entry matches, the fetch is sent to the patched code in the writable region. The block then raises a hit flag and reports which entry matched. When no entry matches, the address passes through unchanged.

Each entry stores the source and the destination as halved addresses, that is, the micro-address shifted right by one bit. The dropped low bit is carried from the fetch address to the output. As a result, one entry always covers a pair of addresses: the even address 2*src maps to 2*dst, and the odd address 2*src+1 maps to 2*dst+1. Entries are written, and can be read back, through a plain indexed register port. A write becomes visible to lookups from the cycle after the write. Sources are intended to lie in the read-only code area below 0x7C00. Destinations are intended to lie in the writable area from 0x7C00 upward.

The lookup is purely combinational, so the block has no state machine. Its only state is the entry table.

Top module: `mp_redirector`

## Requirements
- R1: After reset, every entry reads back as zero on the read port, and no fetch address produces a hit.
- R2: A write with `wr_en` high stores the 31-bit `wr_data` into entry `wr_idx`. From the next cycle, `rd_data` shows that value whenever `rd_idx` selects that entry. The entry layout is: present flag at bit 0, halved source at bits 15:1, halved destination at bits 30:16.
- R3: If a present entry's source field equals `fetch_addr[15:1]` and `fetch_addr[0]` is 0, then `hit` is 1, `hit_idx` is that entry's index, and `out_addr` equals twice its destination field.
- R4: For the odd address of a matching pair, where `fetch_addr[0]` is 1, `out_addr` equals twice the destination field plus one.
- R5: An entry whose present flag (bit 0) is 0 never matches, whatever its source field holds.
- R6: When several present entries match the same address, the entry with the lowest index drives `hit_idx` and `out_addr`.
- R7: With no matching entry, `hit` is 0, `hit_idx` is 0, and `out_addr` equals `fetch_addr`.
- R8: A lookup in the same cycle as a write uses the table contents from before that write. The new contents take effect from the next cycle.
- R9: Entry 0 and entry 31 behave exactly like every other entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset that clears the table |
| wr_en | input | 1 | Write strobe for the entry table |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 31 | Entry value: present bit 0, source half 15:1, destination half 30:16 |
| rd_idx | input | 5 | Index of the entry shown on `rd_data` |
| rd_data | output | 31 | Current contents of entry `rd_idx` |
| fetch_addr | input | 16 | Incoming micro-address |
| out_addr | output | 16 | Redirected or passed-through micro-address |
| hit | output | 1 | High when a present entry matches `fetch_addr` |
| hit_idx | output | 5 | Index of the winning entry, 0 when there is no hit |

## Verification
The region assertion depends on the table contents. It assumes that every present entry is written with a destination field of at least 0x3E00, so that every redirected address lands at 0x7C00 or above. The block itself does not enforce this. The directed stimulus and the pseudo-random stimulus both build destination fields by ORing an offset into 0x3E00, so no entry ever points below the writable area. The read-back assertion assumes only that `rd_idx` may change freely: it skips its check whenever the read index no longer names the entry that was just written.

// File: rtl/mp_pkg.sv
package mp_pkg;

    // Width of a micro-address
    localparam int MP_ADDR_W  = 16;
    // Width of a halved address as stored in an entry
    localparam int MP_HALF_W  = MP_ADDR_W - 1;
    // Width of one table entry: present flag plus two halved addresses
    localparam int MP_ENT_W   = 2 * MP_HALF_W + 1;
    // Default table depth
    localparam int MP_NUM_ENT = 32;
    // First address of the writable code area
    localparam logic [MP_ADDR_W-1:0] MP_WR_BASE = 16'h7C00;

    // Packed entry; the last member occupies bit 0
    typedef struct packed {
        logic [MP_HALF_W-1:0] dst;
        logic [MP_HALF_W-1:0] src;
        logic                 present;
    } mp_entry_t;

endpackage

// File: rtl/mp_entry_bank.sv
module mp_entry_bank
    import mp_pkg::*;
#(
    parameter int NUM_ENT = MP_NUM_ENT,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  mp_entry_t                         wr_ent,
    input  logic [IDX_W-1:0]                  rd_idx,
    output mp_entry_t                         rd_ent,
    input  logic [MP_HALF_W-1:0]              fetch_half,
    output logic [NUM_ENT-1:0]                match_vec,
    output logic [NUM_ENT-1:0]                present_vec,
    output logic [NUM_ENT-1:0][MP_HALF_W-1:0] dst_vec
);

    mp_entry_t ent_view [NUM_ENT];

    // One register and one comparator per entry, all compared in parallel
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        mp_entry_t ent_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_r <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_r <= wr_ent;
            end
        end

        assign ent_view[g]    = ent_r;
        assign present_vec[g] = ent_r.present;
        assign match_vec[g]   = ent_r.present && (ent_r.src == fetch_half);
        assign dst_vec[g]     = ent_r.dst;
    end

    assign rd_ent = ent_view[rd_idx];

endmodule

// File: rtl/mp_prio_sel.sv
module mp_prio_sel
    import mp_pkg::*;
#(
    parameter int NUM_ENT = MP_NUM_ENT,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic [NUM_ENT-1:0]                match_vec,
    input  logic [NUM_ENT-1:0][MP_HALF_W-1:0] dst_vec,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx,
    output logic [MP_HALF_W-1:0]              sel_dst
);

    // Scan from the top down so that the lowest matching index is kept last
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit     = |match_vec;
    assign sel_dst = dst_vec[hit_idx];

endmodule

// File: rtl/mp_redirector.sv
module mp_redirector
    import mp_pkg::*;
#(
    parameter  int NUM_ENT = MP_NUM_ENT,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [MP_ENT_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [MP_ENT_W-1:0]  rd_data,
    input  logic [MP_ADDR_W-1:0] fetch_addr,
    output logic [MP_ADDR_W-1:0] out_addr,
    output logic                 hit,
    output logic [IDX_W-1:0]     hit_idx
);

    mp_entry_t                         wr_ent;
    mp_entry_t                         rd_ent;
    logic [NUM_ENT-1:0]                match_vec;
    logic [NUM_ENT-1:0]                present_vec;
    logic [NUM_ENT-1:0][MP_HALF_W-1:0] dst_vec;
    logic [MP_HALF_W-1:0]              sel_dst;

    assign wr_ent  = mp_entry_t'(wr_data);
    assign rd_data = MP_ENT_W'(rd_ent);

    mp_entry_bank #(
        .NUM_ENT (NUM_ENT),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_ent      (wr_ent),
        .rd_idx      (rd_idx),
        .rd_ent      (rd_ent),
        .fetch_half  (fetch_addr[MP_ADDR_W-1:1]),
        .match_vec   (match_vec),
        .present_vec (present_vec),
        .dst_vec     (dst_vec)
    );

    mp_prio_sel #(
        .NUM_ENT (NUM_ENT),
        .IDX_W   (IDX_W)
    ) u_prio (
        .match_vec (match_vec),
        .dst_vec   (dst_vec),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .sel_dst   (sel_dst)
    );

    // The low address bit is carried through, so one entry covers an even/odd pair
    assign out_addr = hit ? {sel_dst, fetch_addr[0]} : fetch_addr;

endmodule

// File: rtl/mp_redirector_chk.sv
module mp_redirector_chk
    import mp_pkg::*;
#(
    parameter int NUM_ENT = MP_NUM_ENT,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx,
    input logic [MP_ENT_W-1:0]  wr_data,
    input logic [IDX_W-1:0]     rd_idx,
    input logic [MP_ENT_W-1:0]  rd_data,
    input logic [MP_ADDR_W-1:0] fetch_addr,
    input logic [MP_ADDR_W-1:0] out_addr,
    input logic                 hit,
    input logic [IDX_W-1:0]     hit_idx,
    input logic [NUM_ENT-1:0]   match_vec,
    input logic [NUM_ENT-1:0]   present_vec
);

    logic [NUM_ENT-1:0] below_mask;
    assign below_mask = (NUM_ENT'(1) << hit_idx) - NUM_ENT'(1);

    // R2: a written value is visible on the read port in the next cycle
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_idx != $past(wr_idx)) || (rd_data == $past(wr_data))));

    // R3: a reported hit names an entry that really compares equal
    assert_hit_real_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx]);

    // R3: redirected fetches land in the writable area (relies on the stimulus)
    assert_dst_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (out_addr >= MP_WR_BASE));

    // R4: the pair member is kept through the translation
    assert_pair_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (out_addr[0] == fetch_addr[0]));

    // R5: only present entries can win
    assert_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> present_vec[hit_idx]);

    // R6: no lower-index entry matches when one wins
    assert_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec & below_mask) == '0));

    // R7: a miss passes the address through with index zero
    assert_miss_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> ((out_addr == fetch_addr) && (hit_idx == '0)));

endmodule

bind mp_redirector mp_redirector_chk #(
    .NUM_ENT (NUM_ENT),
    .IDX_W   (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .fetch_addr  (fetch_addr),
    .out_addr    (out_addr),
    .hit         (hit),
    .hit_idx     (hit_idx),
    .match_vec   (match_vec),
    .present_vec (present_vec)
);

// File: tb/mp_redirector_tb.sv
module mp_redirector_tb;

    localparam int NUM_ENT = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [30:0] wr_data;
    logic [4:0]  rd_idx;
    logic [30:0] rd_data;
    logic [15:0] fetch_addr;
    logic [15:0] out_addr;
    logic        hit;
    logic [4:0]  hit_idx;

    int    n_checks = 0;
    int    n_err    = 0;
    bit    done     = 1'b0;
    string rd_tag   = "R2";

    logic [30:0] ref_ent [NUM_ENT];

    always #5 clk = ~clk;

    mp_redirector u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .fetch_addr (fetch_addr),
        .out_addr   (out_addr),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    function automatic logic [30:0] mk(input logic [15:0] s, input logic [15:0] d, input logic p);
        return {d[15:1], s[15:1], p};
    endfunction

    // Behavioural reference: the table is an array updated on the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) ref_ent[i] = '0;
        end else if (wr_en) begin
            ref_ent[wr_idx] = wr_data;
        end
    end

    function automatic void model_lookup(input logic [15:0] a, output logic h,
                                         output logic [4:0] ix, output logic [15:0] o);
        h = 1'b0; ix = '0; o = a;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!h && ref_ent[i][0] && (ref_ent[i][15:1] == a[15:1])) begin
                h  = 1'b1;
                ix = 5'(i);
                o  = {ref_ent[i][30:16], a[0]};
            end
        end
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare against the reference in the middle of every cycle
    always @(negedge clk) begin
        logic        e_hit;
        logic [4:0]  e_idx;
        logic [15:0] e_out;
        string       tag;
        if (rst_n === 1'b1 && !done) begin
            model_lookup(fetch_addr, e_hit, e_idx, e_out);
            tag = !e_hit ? "R7" : (fetch_addr[0] ? "R4" : "R3");
            chk(tag, "model hit", 32'(hit), 32'(e_hit));
            chk(tag, "model hit_idx", 32'(hit_idx), 32'(e_idx));
            chk(tag, "model out_addr", 32'(out_addr), 32'(e_out));
            chk(rd_tag, "model rd_data", 32'(rd_data), 32'(ref_ent[rd_idx]));
        end
    end

    task automatic cyc(input logic we, input logic [4:0] wi, input logic [30:0] wd,
                       input logic [15:0] fa, input logic [4:0] ri);
        @(posedge clk);
        #1;
        wr_en = we; wr_idx = wi; wr_data = wd; fetch_addr = fa; rd_idx = ri;
    endtask

    task automatic expect_lu(input string tag, input logic eh, input logic [4:0] ei, input logic [15:0] eo);
        @(negedge clk);
        chk(tag, "hit", 32'(hit), 32'(eh));
        chk(tag, "hit_idx", 32'(hit_idx), 32'(ei));
        chk(tag, "out_addr", 32'(out_addr), 32'(eo));
    endtask

    task automatic expect_rd(input string tag, input logic [30:0] ev);
        chk(tag, "rd_data", 32'(rd_data), 32'(ev));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lf;
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; fetch_addr = '0; rd_idx = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: cleared table, nothing hits
        rd_tag = "R1";
        for (int i = 0; i < NUM_ENT; i++) begin
            cyc(1'b0, '0, '0, 16'(i * 2), 5'(i));
            expect_lu("R1", 1'b0, 5'd0, 16'(i * 2));
            expect_rd("R1", '0);
        end
        rd_tag = "R2";

        // R9 entry 0 and R8 same-cycle write
        cyc(1'b1, 5'd0, mk(16'h0020, 16'h7C40, 1'b1), 16'h0020, 5'd0);
        expect_lu("R8", 1'b0, 5'd0, 16'h0020);
        cyc(1'b0, '0, '0, 16'h0020, 5'd0);
        expect_lu("R9", 1'b1, 5'd0, 16'h7C40);
        expect_rd("R2", mk(16'h0020, 16'h7C40, 1'b1));
        cyc(1'b0, '0, '0, 16'h0021, 5'd0);
        expect_lu("R4", 1'b1, 5'd0, 16'h7C41);
        cyc(1'b0, '0, '0, 16'h0022, 5'd0);
        expect_lu("R7", 1'b0, 5'd0, 16'h0022);
        cyc(1'b0, '0, '0, 16'h001F, 5'd0);
        expect_lu("R7", 1'b0, 5'd0, 16'h001F);

        // R9 entry 31 with R3/R4 pair
        cyc(1'b1, 5'd31, mk(16'h1234, 16'h7D00, 1'b1), 16'h0000, 5'd31);
        cyc(1'b0, '0, '0, 16'h1234, 5'd31);
        expect_lu("R3", 1'b1, 5'd31, 16'h7D00);
        expect_rd("R2", mk(16'h1234, 16'h7D00, 1'b1));
        cyc(1'b0, '0, '0, 16'h1235, 5'd31);
        expect_lu("R9", 1'b1, 5'd31, 16'h7D01);

        // R6: two entries share a source; higher index written first
        cyc(1'b1, 5'd9, mk(16'h0300, 16'h7CA0, 1'b1), 16'h0000, 5'd9);
        cyc(1'b1, 5'd5, mk(16'h0300, 16'h7C80, 1'b1), 16'h0000, 5'd5);
        cyc(1'b0, '0, '0, 16'h0300, 5'd5);
        expect_lu("R6", 1'b1, 5'd5, 16'h7C80);
        // R5: clearing the present flag of the winner hands over to the next one
        cyc(1'b1, 5'd5, mk(16'h0300, 16'h7C80, 1'b0), 16'h0301, 5'd5);
        expect_lu("R6", 1'b1, 5'd5, 16'h7C81);
        cyc(1'b0, '0, '0, 16'h0301, 5'd5);
        expect_lu("R5", 1'b1, 5'd9, 16'h7CA1);
        expect_rd("R2", mk(16'h0300, 16'h7C80, 1'b0));

        // R5: an absent entry alone never matches
        cyc(1'b1, 5'd12, mk(16'h0400, 16'h7D10, 1'b0), 16'h0000, 5'd12);
        cyc(1'b0, '0, '0, 16'h0400, 5'd12);
        expect_lu("R5", 1'b0, 5'd0, 16'h0400);
        cyc(1'b0, '0, '0, 16'h0401, 5'd12);
        expect_lu("R5", 1'b0, 5'd0, 16'h0401);

        // R8: write and lookup in the same cycle, then the next cycle
        cyc(1'b1, 5'd3, mk(16'h0600, 16'h7DF0, 1'b1), 16'h0600, 5'd3);
        expect_lu("R8", 1'b0, 5'd0, 16'h0600);
        cyc(1'b0, '0, '0, 16'h0600, 5'd3);
        expect_lu("R8", 1'b1, 5'd3, 16'h7DF0);
        // R8: overwrite keeps the old mapping during the writing cycle
        cyc(1'b1, 5'd31, mk(16'h1234, 16'h7DFC, 1'b1), 16'h1234, 5'd31);
        expect_lu("R8", 1'b1, 5'd31, 16'h7D00);
        cyc(1'b0, '0, '0, 16'h1234, 5'd31);
        expect_lu("R8", 1'b1, 5'd31, 16'h7DFC);

        // Pseudo-random traffic, checked against the reference every cycle
        lf = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            logic [15:0] nx;
            logic        we;
            nx = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lf = nx;
            we = (lf[2:0] == 3'b101);
            cyc(we, lf[12:8],
                {15'h3E00 | 15'(lf[15:8]), 8'h00, lf[6:0], lf[13] | lf[14]},
                {8'h00, lf[7:0] ^ lf[15:8]}, lf[4:0] ^ lf[9:5]);
        end

        @(posedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule